// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Controller

The controller gathers a bank of interrupt request lines and drives the two interrupt inputs of a processor core. Line 0 is routed straight to a fast interrupt output. The remaining lines (line 1 carries the aggregated system-peripheral request, lines 2 and up serve peripheral or external requests) go through a priority resolver with eight levels, and the resolver drives a normal interrupt output.

Software programs each line through a small register bus. It sets the trigger mode, the polarity, the priority and a 32-bit handler vector for each line. It can enable or disable lines with set and clear masks. A read of the vector register returns the handler vector of the winning line and marks that line's level as in service on a hardware stack. An end-of-interrupt write then restores the level that was in service before. While a line is in service, only a strictly higher level can interrupt again, so handlers can nest. A protect bit makes vector reads free of side effects, for debuggers. A global mask bit silences both outputs but keeps recording pending lines, so software can poll them.

The register bus has an 8-bit address. A write takes effect at the clock edge where `bus_wr` is sampled high. A read returns its data on `bus_rdata` from the edge where `bus_rd` is sampled high, and any side effect of the read also happens at that edge. Reads and writes are never issued in the same cycle. Request inputs are synchronous to `clk`.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Line 0 drives `irq_fast` whenever it is pending and enabled, independent of any priority or in-service state. It never drives `irq_norm`.
- R2: A write to 0x41 sets the enable bits given as ones in the data. A write to 0x42 clears them. A read of 0x41 returns the enables. A disabled line drives neither output.
- R3: Among pending, enabled lines 1..31, the resolver picks the highest priority. When priorities tie, the lower line number wins.
- R4: While the stack holds level L, `irq_norm` is high only if some pending, enabled line has a priority strictly above L. With the stack empty, any such line raises it.
- R5: A read of 0x40 while `irq_norm` would be asserted returns the winning line's vector. The vectors are written at 0x20+n. The read also pushes that line's priority onto the stack.
- R6: Writing 0x00+n sets line n's configuration: bits [2:0] are the priority, bit 3 selects edge (1) or level (0), and bit 4 inverts the polarity (falling edge or low level). Level lines are pending while active. Edge lines latch pending on the selected edge.
- R7: With control bit 0 (protect, address 0x45) set, a vector read returns the same vector but leaves the stack and the edge flags unchanged.
- R8: With control bit 1 (global mask) set, both outputs stay low. The pending lines can still be read at 0x46, one bit per line.
- R9: A write to 0x43 (end of interrupt) pops the stack and restores the previous in-service level. On an empty stack the write has no effect.
- R10: A vector read when no line qualifies returns the spurious vector written at 0x44, and the stack is left unchanged.
- R11: An edge flag clears on a non-protected vector read that selects its line, or on a write to 0x47 with that line's bit set. A level line stays pending until its input goes inactive.
- R12: After reset, both outputs are low, all lines are disabled, the stack is empty, and all vectors and the spurious vector are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_src | input | NSRC | Interrupt request lines |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, registered |
| irq_norm | output | 1 | Normal interrupt request to the core |
| irq_fast | output | 1 | Fast interrupt request to the core |

## Verification
The bench raises two lines of equal priority. It expects the lower number to win, and it expects the twin not to re-raise the normal request while the first is in service. A resolver that uses greater-or-equal, or a nesting check that is not strict, would fail there. It nests a high level over a low one and unwinds with end-of-interrupt writes, including one extra write on an empty stack. A pointer that underflows on that write would later turn a valid vector read into a spurious one. It reads the vector while the only pending line is below the level in service, which must return the spurious vector without a push; a push there would leave the stack one level deep after a single end-of-interrupt. It also checks that protected reads leave edge flags latched, that falling-edge and low-level polarities respond only to the inverted condition, and that the global mask hides requests while the pending register still shows them.

// File: rtl/prio_irq_pkg.sv
// Shared constants of the interrupt controller: register map and field positions.
// Assumes an 8-bit register address and at most 32 request lines.
package prio_irq_pkg;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] CFG_BASE = 8'h00;
    localparam logic [ADDR_W-1:0] VEC_BASE = 8'h20;
    localparam logic [ADDR_W-1:0] A_IVR    = 8'h40;
    localparam logic [ADDR_W-1:0] A_ENSET  = 8'h41;
    localparam logic [ADDR_W-1:0] A_ENCLR  = 8'h42;
    localparam logic [ADDR_W-1:0] A_EOI    = 8'h43;
    localparam logic [ADDR_W-1:0] A_SPUR   = 8'h44;
    localparam logic [ADDR_W-1:0] A_CTRL   = 8'h45;
    localparam logic [ADDR_W-1:0] A_PEND   = 8'h46;
    localparam logic [ADDR_W-1:0] A_ECLR   = 8'h47;

    localparam int CTRL_PROTECT = 0;
    localparam int CTRL_GMASK   = 1;
endpackage

// File: rtl/irq_src_cond.sv
// Per-line request conditioning: polarity, edge latch or level pass-through.
// Assumes irq_in is synchronous to clk. A set edge wins over a clear in the same cycle.
module irq_src_cond #(
    parameter int NSRC = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] irq_in,
    input  logic [NSRC-1:0] edge_mode,
    input  logic [NSRC-1:0] invert,
    input  logic [NSRC-1:0] clr,
    output logic [NSRC-1:0] pend
);
    for (genvar i = 0; i < NSRC; i++) begin : g_line
        logic prev_q;
        logic flag_q;
        logic hit;

        // selected edge on the raw input
        assign hit = invert[i] ? (prev_q & ~irq_in[i]) : (irq_in[i] & ~prev_q);

        // track the raw input and latch edge events
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prev_q <= 1'b0;
                flag_q <= 1'b0;
            end else begin
                prev_q <= irq_in[i];
                if (edge_mode[i] && hit) flag_q <= 1'b1;
                else if (clr[i])         flag_q <= 1'b0;
            end
        end

        assign pend[i] = edge_mode[i] ? flag_q : (irq_in[i] ^ invert[i]);
    end
endmodule

// File: rtl/irq_prio_resolve.sv
// Combinational winner search: highest priority, ties to the lowest index.
// Assumes the caller masks out lines that must not compete.
module irq_prio_resolve #(
    parameter int NSRC   = 32,
    parameter int PRIO_W = 3,
    localparam int IDX_W = $clog2(NSRC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   cand,
    input  logic [PRIO_W-1:0] prio [NSRC],
    output logic              valid,
    output logic [IDX_W-1:0]  idx,
    output logic [PRIO_W-1:0] best
);
    // linear scan, strict compare keeps the lower index on a tie
    always_comb begin
        valid = 1'b0;
        idx   = '0;
        best  = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (cand[i] && (!valid || prio[i] > best)) begin
                valid = 1'b1;
                idx   = IDX_W'(i);
                best  = prio[i];
            end
        end
    end

    // R3: the reported winner is always a competing line
    assert_winner_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> cand[idx]);
endmodule

// File: rtl/irq_prio_stack.sv
// Stack of in-service priority levels, one entry per nesting depth.
// Assumes each push carries a level strictly above the top, so depth never exceeds 2**PRIO_W.
module irq_prio_stack #(
    parameter int PRIO_W = 3,
    localparam int DEPTH = 2 ** PRIO_W,
    localparam int PTR_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [PRIO_W-1:0] push_prio,
    input  logic              pop,
    output logic              active,
    output logic [PRIO_W-1:0] top_prio
);
    logic [PRIO_W-1:0] lvl_q [DEPTH];
    logic [PTR_W-1:0]  ptr_q;

    // depth pointer; a pop on an empty stack is dropped
    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else if (push) ptr_q <= ptr_q + PTR_W'(1);
        else if (pop && ptr_q != '0) ptr_q <= ptr_q - PTR_W'(1);
    end

    // level storage, written on push
    always_ff @(posedge clk) begin
        if (push) lvl_q[ptr_q[PRIO_W-1:0]] <= push_prio;
    end

    assign active   = (ptr_q != '0);
    assign top_prio = active ? lvl_q[PRIO_W'(ptr_q - PTR_W'(1))] : '0;

    // R4: nesting never runs past one entry per level
    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> ptr_q < PTR_W'(DEPTH));
    // R4: each nested level is strictly above the one it preempts
    assert_nest_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (push && active) |-> push_prio > top_prio);
    // R9: end of interrupt on an empty stack leaves it empty
    assert_empty_eoi_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !active) |=> !active);
endmodule

// File: rtl/prio_irq_ctrl.sv
// Top of the vectored interrupt controller: register bus, masks, vector read and nesting.
// Assumes bus_rd and bus_wr are never high together and NSRC <= DATA_W <= 32 bits of map room.
module prio_irq_ctrl
    import prio_irq_pkg::*;
#(
    parameter int NSRC   = 32,
    parameter int PRIO_W = 3,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(NSRC),
    localparam int F_EDGE = PRIO_W,
    localparam int F_INV  = PRIO_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   irq_src,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_norm,
    output logic              irq_fast
);
    logic [NSRC-1:0]   en_q, edge_q, inv_q;
    logic [PRIO_W-1:0] prio_q [NSRC];
    logic [DATA_W-1:0] vec_q  [NSRC];
    logic [DATA_W-1:0] spur_q, rdata_q;
    logic              protect_q, gmask_q;

    logic [NSRC-1:0]   pend, cand, cand_n, clr;
    logic              best_valid, eligible, ivr_rd, take, eoi;
    logic [IDX_W-1:0]  best_idx;
    logic [PRIO_W-1:0] best_prio, stk_top;
    logic              stk_active;

    irq_src_cond #(.NSRC(NSRC)) u_cond (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_src), .edge_mode(edge_q),
        .invert(inv_q), .clr(clr), .pend(pend)
    );

    assign cand   = pend & en_q;
    assign cand_n = {cand[NSRC-1:1], 1'b0};

    irq_prio_resolve #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_resolve (
        .clk(clk), .rst_n(rst_n), .cand(cand_n), .prio(prio_q),
        .valid(best_valid), .idx(best_idx), .best(best_prio)
    );

    irq_prio_stack #(.PRIO_W(PRIO_W)) u_stack (
        .clk(clk), .rst_n(rst_n), .push(take), .push_prio(best_prio),
        .pop(eoi), .active(stk_active), .top_prio(stk_top)
    );

    assign eligible = best_valid && (!stk_active || best_prio > stk_top);
    assign irq_norm = eligible && !gmask_q;
    assign irq_fast = cand[0] && !gmask_q;
    assign ivr_rd   = bus_rd && bus_addr == A_IVR;
    assign take     = ivr_rd && eligible && !protect_q;
    assign eoi      = bus_wr && bus_addr == A_EOI;
    assign bus_rdata = rdata_q;

    // edge flag clears: serviced line and explicit clear mask
    always_comb begin
        clr = '0;
        if (take) clr[best_idx] = 1'b1;
        if (bus_wr && bus_addr == A_ECLR) clr = clr | bus_wdata[NSRC-1:0];
    end

    // register writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q      <= '0;
            edge_q    <= '0;
            inv_q     <= '0;
            spur_q    <= '0;
            protect_q <= 1'b0;
            gmask_q   <= 1'b0;
            for (int i = 0; i < NSRC; i++) begin
                prio_q[i] <= '0;
                vec_q[i]  <= '0;
            end
        end else if (bus_wr) begin
            case (bus_addr)
                A_ENSET: en_q <= en_q | bus_wdata[NSRC-1:0];
                A_ENCLR: en_q <= en_q & ~bus_wdata[NSRC-1:0];
                A_SPUR:  spur_q <= bus_wdata;
                A_CTRL: begin
                    protect_q <= bus_wdata[CTRL_PROTECT];
                    gmask_q   <= bus_wdata[CTRL_GMASK];
                end
                default: ;
            endcase
            for (int i = 0; i < NSRC; i++) begin
                if (bus_addr == ADDR_W'(int'(CFG_BASE) + i)) begin
                    prio_q[i] <= bus_wdata[PRIO_W-1:0];
                    edge_q[i] <= bus_wdata[F_EDGE];
                    inv_q[i]  <= bus_wdata[F_INV];
                end
                if (bus_addr == ADDR_W'(int'(VEC_BASE) + i)) vec_q[i] <= bus_wdata;
            end
        end
    end

    // registered read data; the vector read returns winner or spurious vector
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (bus_rd) begin
            rdata_q <= '0;
            case (bus_addr)
                A_IVR:   rdata_q <= eligible ? vec_q[best_idx] : spur_q;
                A_ENSET: rdata_q <= DATA_W'(en_q);
                A_PEND:  rdata_q <= DATA_W'(pend);
                A_SPUR:  rdata_q <= spur_q;
                A_CTRL:  rdata_q <= DATA_W'({gmask_q, protect_q});
                default: ;
            endcase
            for (int i = 0; i < NSRC; i++) begin
                if (bus_addr == ADDR_W'(int'(CFG_BASE) + i))
                    rdata_q <= DATA_W'({inv_q[i], edge_q[i], prio_q[i]});
                if (bus_addr == ADDR_W'(int'(VEC_BASE) + i)) rdata_q <= vec_q[i];
            end
        end
    end

    // R7: a protected vector read leaves the in-service state alone
    assert_protect_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ivr_rd && protect_q && !bus_wr) |=> ($stable(stk_active) && $stable(stk_top)));
    // R10: a read with nothing qualifying returns the spurious vector
    assert_spurious_vec_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ivr_rd && !eligible) |=> bus_rdata == $past(spur_q));
    // R10: a read with nothing qualifying does not change the stack
    assert_spurious_stack_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ivr_rd && !eligible && !bus_wr) |=> ($stable(stk_active) && $stable(stk_top)));
endmodule

// File: tb/prio_irq_ctrl_bench.sv
// Directed bench for the interrupt controller, one task per scenario.
module prio_irq_ctrl_bench;
    localparam int NSRC = 32;
    localparam logic [31:0] SPUR = 32'hDEAD_BEEF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [NSRC-1:0] irq_src = '0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_norm, irq_fast;
    int checks = 0, fails = 0;
    bit done = 0;

    prio_irq_ctrl u_prio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_norm(irq_norm), .irq_fast(irq_fast)
    );

    always #10 clk = ~clk;

    function automatic logic [31:0] vexp(input int n);
        return 32'hA000_0000 | (n * 32'h111);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic drive(input int n, input logic v);
        irq_src[n] = v;
        @(negedge clk);
    endtask

    task automatic pulse(input int n);
        irq_src[n] = 1'b1;
        @(negedge clk);
        irq_src[n] = 1'b0;
        @(negedge clk);
    endtask

    task automatic eoi();
        wr(8'h43, 32'h0);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R12 norm", {31'b0, irq_norm}, 0);
        chk("R12 fast", {31'b0, irq_fast}, 0);
        rd(8'h41, d); chk("R12 enables", d, 0);
        rd(8'h40, d); chk("R12 spurious zero", d, 0);
        rd(8'h25, d); chk("R12 vector zero", d, 0);
    endtask

    task automatic t_fast();
        wr(8'h00, 32'h0);
        wr(8'h41, 32'h1);
        drive(0, 1'b1);
        chk("R1 fast on", {31'b0, irq_fast}, 1);
        chk("R1 norm off", {31'b0, irq_norm}, 0);
        wr(8'h42, 32'h1);
        chk("R2 disabled fast", {31'b0, irq_fast}, 0);
        drive(0, 1'b0);
        wr(8'h00, 32'h8);
        wr(8'h41, 32'h1);
        pulse(0);
        chk("R6 fast edge latched", {31'b0, irq_fast}, 1);
        wr(8'h47, 32'h1);
        chk("R11 edge clear cmd", {31'b0, irq_fast}, 0);
        wr(8'h42, 32'h1);
    endtask

    task automatic t_prio();
        logic [31:0] d;
        wr(8'h05, 32'd3); wr(8'h09, 32'd3); wr(8'h0C, 32'd1);
        wr(8'h41, (32'h1 << 5) | (32'h1 << 9) | (32'h1 << 12));
        irq_src[5] = 1'b1; irq_src[9] = 1'b1; irq_src[12] = 1'b1;
        @(negedge clk);
        chk("R3 norm raised", {31'b0, irq_norm}, 1);
        rd(8'h40, d); chk("R3 tie lower index", d, vexp(5));
        chk("R4 equal level held off", {31'b0, irq_norm}, 0);
        eoi();
        chk("R9 pop re-raises", {31'b0, irq_norm}, 1);
        drive(5, 1'b0);
        rd(8'h40, d); chk("R3 next winner", d, vexp(9));
        eoi();
        drive(9, 1'b0);
        rd(8'h40, d); chk("R5 low line vector", d, vexp(12));
        chk("R5 in service", {31'b0, irq_norm}, 0);
    endtask

    task automatic t_nest();
        logic [31:0] d;
        wr(8'h14, 32'd6);
        wr(8'h41, 32'h1 << 20);
        drive(20, 1'b1);
        chk("R4 higher preempts", {31'b0, irq_norm}, 1);
        rd(8'h40, d); chk("R5 nested vector", d, vexp(20));
        chk("R4 nested held", {31'b0, irq_norm}, 0);
        drive(20, 1'b0);
        eoi();
        chk("R9 restores level 1", {31'b0, irq_norm}, 0);
        eoi();
        chk("R9 empty re-raises", {31'b0, irq_norm}, 1);
        eoi();
        rd(8'h40, d); chk("R9 empty pop ignored", d, vexp(12));
        chk("R9 push after empty pop", {31'b0, irq_norm}, 0);
        eoi();
    endtask

    task automatic t_spur();
        logic [31:0] d;
        drive(20, 1'b1);
        rd(8'h40, d); chk("R5 vector 20", d, vexp(20));
        drive(20, 1'b0);
        rd(8'h40, d); chk("R10 spurious lower", d, SPUR);
        eoi();
        chk("R10 stack unchanged", {31'b0, irq_norm}, 1);
        drive(12, 1'b0);
        rd(8'h40, d); chk("R10 spurious none", d, SPUR);
        wr(8'h42, (32'h1 << 5) | (32'h1 << 9) | (32'h1 << 20));
    endtask

    task automatic t_edge();
        logic [31:0] d;
        wr(8'h07, 32'h8 | 32'd2);
        wr(8'h41, 32'h1 << 7);
        pulse(7);
        chk("R6 rising latched", {31'b0, irq_norm}, 1);
        rd(8'h40, d); chk("R6 rising vector", d, vexp(7));
        eoi();
        chk("R11 flag cleared by read", {31'b0, irq_norm}, 0);
        drive(8, 1'b1);
        wr(8'h08, 32'h18 | 32'd2);
        wr(8'h41, 32'h1 << 8);
        chk("R6 falling ignores high", {31'b0, irq_norm}, 0);
        drive(8, 1'b0);
        chk("R6 falling latched", {31'b0, irq_norm}, 1);
        rd(8'h40, d); chk("R6 falling vector", d, vexp(8));
        eoi();
        chk("R11 falling cleared", {31'b0, irq_norm}, 0);
        drive(10, 1'b1);
        wr(8'h0A, 32'h10 | 32'd4);
        wr(8'h41, 32'h1 << 10);
        chk("R6 low level idle", {31'b0, irq_norm}, 0);
        drive(10, 1'b0);
        chk("R6 low level active", {31'b0, irq_norm}, 1);
        rd(8'h40, d); chk("R6 low level vector", d, vexp(10));
        eoi();
        chk("R11 level stays", {31'b0, irq_norm}, 1);
        drive(10, 1'b1);
        chk("R11 level released", {31'b0, irq_norm}, 0);
        wr(8'h42, 32'h1 << 10);
    endtask

    task automatic t_protect();
        logic [31:0] d;
        wr(8'h45, 32'h1);
        pulse(7);
        rd(8'h40, d); chk("R7 protected vector", d, vexp(7));
        chk("R7 no side effect", {31'b0, irq_norm}, 1);
        wr(8'h45, 32'h0);
        rd(8'h40, d); chk("R7 normal read", d, vexp(7));
        chk("R7 serviced", {31'b0, irq_norm}, 0);
        eoi();
        chk("R11 flag gone", {31'b0, irq_norm}, 0);
    endtask

    task automatic t_gmask();
        logic [31:0] d;
        wr(8'h45, 32'h2);
        wr(8'h00, 32'h0);
        wr(8'h41, 32'h1 | (32'h1 << 12));
        irq_src[0] = 1'b1; irq_src[12] = 1'b1;
        @(negedge clk);
        chk("R8 norm masked", {31'b0, irq_norm}, 0);
        chk("R8 fast masked", {31'b0, irq_fast}, 0);
        rd(8'h46, d); chk("R8 pending visible", d, 32'h0000_1001);
        wr(8'h45, 32'h0);
        chk("R8 norm unmasked", {31'b0, irq_norm}, 1);
        chk("R1 fast unmasked", {31'b0, irq_fast}, 1);
        irq_src[0] = 1'b0; irq_src[12] = 1'b0;
        @(negedge clk);
        chk("R2 lines idle", {30'b0, irq_norm, irq_fast}, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        for (int i = 0; i < NSRC; i++) wr(8'h20 + 8'(i), vexp(i));
        wr(8'h44, SPUR);
        t_fast();
        t_prio();
        t_nest();
        t_spur();
        t_edge();
        t_protect();
        t_gmask();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule